// File: doc/BRIEF.md
# Dual-Oscillator Temperature Counter with Alarm

This block is the digital core of a temperature converter that measures one oscillator against another. A clock enable derived from a low-temperature-coefficient oscillator decrements a down-counter. The counter only runs while a gate window, derived from a high-temperature-coefficient oscillator, is high. Each time the counter runs out inside the window, a half-degree temperature register steps up by one. The counter is then reloaded from a slope accumulator, and the accumulator grows by a fixed step. This follows the non-linear shape of the oscillator pair.

A start pulse presets the counter, the accumulator and the temperature register to the coldest code (−55 °C). When the gate window closes, the block publishes the temperature as a sign-extended 16-bit word and keeps the leftover count and the current slope value, so that software can interpolate below half a degree. The integer part of the temperature is compared with two signed 8-bit limits, and an alarm flag is set or cleared. A single-cycle done pulse marks the moment the results change.

Top module: `temp_osc_counter`

## Requirements
- R1: While reset is asserted, and until the first conversion completes, all result outputs read zero, and `busy` and `donePulse` are low.
- R2: A start pulse while idle presets the internal counter to `BASE_COUNT`, the slope value to `SLOPE_BASE` and the temperature to the −55 °C code. A conversion with no counted tick therefore reports `tempWord` = 16'hFF92, `countLeft` = `BASE_COUNT` and `countPerStep` = `SLOPE_BASE`.
- R3: A tick is counted on a clock cycle only when `busy`, `gateIn` and `tickEn` are all high. A counted tick on a counter value of 1 raises the temperature by one half-degree LSB, reloads the counter with the slope value and adds `SLOPE_STEP` to the slope value. Otherwise it decrements the counter, so the reported leftover count is never zero.
- R4: The conversion ends on the first clock edge that samples `gateIn` low after it has been sampled high. `donePulse` is high for exactly the next cycle, and `busy` is low in that same cycle. The result outputs and the alarm change only in that cycle.
- R5: While `gateIn` has not yet been sampled high during a conversion, a low `gateIn` does not end it.
- R6: A start pulse while `busy` is high has no effect on the running conversion.
- R7: `tempWord` is a two's-complement count of half degrees in bits 8:0, with bits 15:9 copying bit 8 (−25 °C = 16'hFFCE, −0.5 °C = 16'hFFFF).
- R8: The temperature stops at the +125 °C code (16'h00FA). Once it is there, counted ticks change neither the counter nor the slope value, and the conversion still ends normally.
- R9: The alarm uses the temperature with its half-degree bit dropped (an arithmetic shift right by one, so −0.5 °C gives −1). The alarm is set when that value is greater than signed `limitHigh` or less than signed `limitLow`, with the limits taken at the end of the conversion.
- R10: The alarm is worked out again at every conversion end, so it clears when the new result is inside the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins a conversion when idle |
| gateIn | input | 1 | Gate window from the high-coefficient oscillator |
| tickEn | input | 1 | Count enable from the low-coefficient oscillator |
| limitHigh | input | 8 | Signed upper alarm limit, whole degrees |
| limitLow | input | 8 | Signed lower alarm limit, whole degrees |
| tempWord | output | 16 | Sign-extended half-degree temperature |
| countLeft | output | CNT_W | Counter value left when the gate closed |
| countPerStep | output | CNT_W | Slope value when the gate closed |
| alarmFlag | output | 1 | Temperature outside the limits |
| donePulse | output | 1 | One-cycle marker that results were updated |
| busy | output | 1 | Conversion in progress |

## Verification
A miscounted tick, a missed reload or a wrong slope increment stays hidden until the gate closes. It then shows in the cycle of `donePulse` as a mismatch in `tempWord`, `countLeft` or `countPerStep` against an arithmetic model of the reload chain. Conversions are swept over many tick counts so that each reload boundary is hit. A wrong shift or wrong signedness in the comparison shows up as the alarm flipping at limit equality or at −0.5 °C. A saturation fault only appears after the long run to +125 °C, as a code above 16'h00FA or as a leftover count that keeps moving.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
  localparam int TEMP_W = 9;
  localparam int WORD_W = 16;
  localparam logic signed [TEMP_W-1:0] TEMP_MIN = -9'sd110;
  localparam logic signed [TEMP_W-1:0] TEMP_MAX = 9'sd250;

  typedef struct packed {
    logic preset;
    logic tick;
    logic capture;
  } tcvStrobe_t;
endpackage

// File: rtl/tcv_ctrl.sv
module tcv_ctrl
  import tcv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       gateIn,
  input  logic       tickEn,
  output tcvStrobe_t strobe,
  output logic       busy,
  output logic       donePulse
);
  logic running;
  logic seenGate;

  always_comb begin
    strobe         = '0;
    strobe.preset  = !running && startPulse;
    strobe.tick    = running && gateIn && tickEn;
    strobe.capture = running && seenGate && !gateIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      seenGate  <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= strobe.capture;
      if (strobe.preset) begin
        running  <= 1'b1;
        seenGate <= 1'b0;
      end else if (strobe.capture) begin
        running  <= 1'b0;
      end else if (running && gateIn) begin
        seenGate <= 1'b1;
      end
    end
  end

  assign busy = running;
endmodule

// File: rtl/tcv_datapath.sv
module tcv_datapath
  import tcv_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BASE_COUNT = 300,
  parameter int SLOPE_BASE = 40,
  parameter int SLOPE_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcvStrobe_t        strobe,
  input  logic [7:0]        limitHigh,
  input  logic [7:0]        limitLow,
  output logic [WORD_W-1:0] tempWord,
  output logic [CNT_W-1:0]  countLeft,
  output logic [CNT_W-1:0]  countPerStep,
  output logic              alarmFlag
);
  localparam int EXT_W = WORD_W - TEMP_W;
  localparam logic [CNT_W-1:0] BASE_V  = CNT_W'(BASE_COUNT);
  localparam logic [CNT_W-1:0] SLOPE_V = CNT_W'(SLOPE_BASE);
  localparam logic [CNT_W-1:0] STEP_V  = CNT_W'(SLOPE_STEP);

  logic [CNT_W-1:0]         downCnt;
  logic [CNT_W-1:0]         slopeAcc;
  logic signed [TEMP_W-1:0] tempReg;
  logic                     atTop;
  logic signed [7:0]        wholeDeg;
  logic                     outside;

  assign atTop    = (tempReg == TEMP_MAX);
  assign wholeDeg = tempReg[TEMP_W-1:1];
  assign outside  = (wholeDeg > $signed(limitHigh)) || (wholeDeg < $signed(limitLow));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      downCnt  <= '0;
      slopeAcc <= '0;
      tempReg  <= '0;
    end else if (strobe.preset) begin
      downCnt  <= BASE_V;
      slopeAcc <= SLOPE_V;
      tempReg  <= TEMP_MIN;
    end else if (strobe.tick && !atTop) begin
      if (downCnt == CNT_W'(1)) begin
        tempReg  <= tempReg + 9'sd1;
        downCnt  <= slopeAcc;
        slopeAcc <= slopeAcc + STEP_V;
      end else begin
        downCnt <= downCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempWord     <= '0;
      countLeft    <= '0;
      countPerStep <= '0;
      alarmFlag    <= 1'b0;
    end else if (strobe.capture) begin
      tempWord     <= {{EXT_W{tempReg[TEMP_W-1]}}, tempReg};
      countLeft    <= downCnt;
      countPerStep <= slopeAcc;
      alarmFlag    <= outside;
    end
  end
endmodule

// File: rtl/temp_osc_counter.sv
module temp_osc_counter
  import tcv_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BASE_COUNT = 300,
  parameter int SLOPE_BASE = 40,
  parameter int SLOPE_STEP = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             gateIn,
  input  logic             tickEn,
  input  logic [7:0]       limitHigh,
  input  logic [7:0]       limitLow,
  output logic [15:0]      tempWord,
  output logic [CNT_W-1:0] countLeft,
  output logic [CNT_W-1:0] countPerStep,
  output logic             alarmFlag,
  output logic             donePulse,
  output logic             busy
);
  tcvStrobe_t strobe;

  tcv_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .gateIn     (gateIn),
    .tickEn     (tickEn),
    .strobe     (strobe),
    .busy       (busy),
    .donePulse  (donePulse)
  );

  tcv_datapath #(
    .CNT_W      (CNT_W),
    .BASE_COUNT (BASE_COUNT),
    .SLOPE_BASE (SLOPE_BASE),
    .SLOPE_STEP (SLOPE_STEP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .limitHigh    (limitHigh),
    .limitLow     (limitLow),
    .tempWord     (tempWord),
    .countLeft    (countLeft),
    .countPerStep (countPerStep),
    .alarmFlag    (alarmFlag)
  );
endmodule

// File: rtl/tcv_checker.sv
module tcv_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateIn,
  input logic [15:0]      tempWord,
  input logic [CNT_W-1:0] countLeft,
  input logic             alarmFlag,
  input logic             donePulse,
  input logic             busy
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R4
  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(!gateIn && busy)); // R4
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> ($stable(tempWord) && $stable(alarmFlag))); // R4
  AST_TEMP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ($signed(tempWord) >= -16'sd110 && $signed(tempWord) <= 16'sd250)); // R8
  AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (countLeft != '0)); // R3
endmodule

bind temp_osc_counter tcv_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gateIn    (gateIn),
  .tempWord  (tempWord),
  .countLeft (countLeft),
  .alarmFlag (alarmFlag),
  .donePulse (donePulse),
  .busy      (busy)
);

// File: tb/sim_temp_osc_counter.sv
module sim_temp_osc_counter;
  localparam int CW    = 10;
  localparam int BASE  = 3;
  localparam int SBASE = 1;
  localparam int SSTEP = 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          gateIn = 1'b0;
  logic          tickEn = 1'b0;
  logic [7:0]    limitHigh = 8'h7F;
  logic [7:0]    limitLow = 8'h80;
  logic [15:0]   tempWord;
  logic [CW-1:0] countLeft;
  logic [CW-1:0] countPerStep;
  logic          alarmFlag;
  logic          donePulse;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  temp_osc_counter #(
    .CNT_W(CW), .BASE_COUNT(BASE), .SLOPE_BASE(SBASE), .SLOPE_STEP(SSTEP)
  ) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .gateIn(gateIn), .tickEn(tickEn),
    .limitHigh(limitHigh), .limitLow(limitLow), .tempWord(tempWord),
    .countLeft(countLeft), .countPerStep(countPerStep), .alarmFlag(alarmFlag),
    .donePulse(donePulse), .busy(busy)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic void model(int ticks, output int t, output int c, output int s);
    t = -110; c = BASE; s = SBASE;
    for (int i = 0; i < ticks; i++) begin
      if (t != 250) begin
        if (c == 1) begin t++; c = s; s += SSTEP; end
        else c--;
      end
    end
  endfunction

  task automatic convert(string req, int ticks, bit alt, bit midStart, int preLow,
                         logic [7:0] th, logic [7:0] tl);
    int t, c, s, n, cyc, whole, expAlarm;
    @(negedge clk);
    limitHigh = th; limitLow = tl; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (preLow > 0) begin
      repeat (preLow) @(negedge clk);
      chk("R5", "busy while gate not yet seen", int'(busy), 1);
      chk("R5", "no done before gate", int'(donePulse), 0);
    end
    gateIn = 1'b1; tickEn = 1'b0;
    @(negedge clk);
    n = 0; cyc = 0;
    while (n < ticks) begin
      tickEn = !alt || cyc[0];
      if (tickEn) n++;
      startPulse = midStart && (cyc == 1);
      cyc++;
      @(negedge clk);
    end
    startPulse = 1'b0;
    tickEn = 1'b0;
    chk("R4", "no done while gate high", int'(donePulse), 0);
    gateIn = 1'b0;
    @(negedge clk);
    model(ticks, t, c, s);
    whole = t >>> 1;
    expAlarm = (whole > int'($signed(th))) || (whole < int'($signed(tl)));
    chk("R4", "done pulse", int'(donePulse), 1);
    chk("R4", "busy low at done", int'(busy), 0);
    chk(req, "tempWord", int'(tempWord), t & 16'hFFFF);
    chk("R3", "countLeft", int'(countLeft), c);
    chk("R3", "countPerStep", int'(countPerStep), s);
    chk("R9", "alarmFlag", int'(alarmFlag), expAlarm);
    @(negedge clk);
    chk("R4", "done lasts one cycle", int'(donePulse), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "tempWord in reset", int'(tempWord), 0);
    chk("R1", "countLeft in reset", int'(countLeft), 0);
    chk("R1", "alarm in reset", int'(alarmFlag), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "done in reset", int'(donePulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "tempWord after reset", int'(tempWord), 0);

    // R2: no counted ticks gives the preset values
    convert("R2", 0, 1'b0, 1'b0, 0, 8'h7D, 8'h80);
    chk("R2", "preset code", int'(tempWord), 16'hFF92);
    chk("R2", "preset count", int'(countLeft), BASE);
    chk("R2", "preset slope", int'(countPerStep), SBASE);

    // R9/R10: limit boundaries at -55 whole degrees
    convert("R9", 0, 1'b0, 1'b0, 0, 8'h00, 8'hCA);
    chk("R9", "below low limit", int'(alarmFlag), 1);
    convert("R10", 0, 1'b0, 1'b0, 0, 8'h00, 8'hC9);
    chk("R10", "equal to low limit clears", int'(alarmFlag), 0);
    convert("R9", 0, 1'b0, 1'b0, 0, 8'hC8, 8'h80);
    chk("R9", "above high limit", int'(alarmFlag), 1);
    convert("R10", 0, 1'b0, 1'b0, 0, 8'hC9, 8'h80);
    chk("R10", "equal to high limit clears", int'(alarmFlag), 0);

    // R3: sweep of tick counts across many reload boundaries
    for (int k = 1; k <= 40; k++)
      convert("R3", k, 1'b0, 1'b0, 0, 8'h7F, 8'h80);
    // R3: tickEn gating with alternating enable
    for (int k = 5; k <= 25; k += 5)
      convert("R3", k, 1'b1, 1'b0, 0, 8'h7F, 8'h80);
    // R5: gate low for a while after start
    convert("R5", 7, 1'b0, 1'b0, 4, 8'h7F, 8'h80);
    // R6: start pulse mid-conversion is ignored
    convert("R6", 12, 1'b0, 1'b1, 0, 8'h7F, 8'h80);
    convert("R6", 9, 1'b1, 1'b1, 2, 8'h7F, 8'h80);

    // R7: -25 degrees and -0.5 degrees encodings
    convert("R7", 1773, 1'b0, 1'b0, 0, 8'h7F, 8'h80);
    chk("R7", "-25 C code", int'(tempWord), 16'hFFCE);
    convert("R7", 5889, 1'b0, 1'b0, 0, 8'hFF, 8'hFF);
    chk("R7", "-0.5 C code", int'(tempWord), 16'hFFFF);
    chk("R9", "-0.5 C whole part is -1", int'(alarmFlag), 0);

    // R8: saturation at +125 and alarm above high limit
    convert("R8", 64623 + 50, 1'b0, 1'b0, 0, 8'h7C, 8'h80);
    chk("R8", "+125 C code", int'(tempWord), 16'h00FA);
    chk("R8", "counter frozen", int'(countLeft), 360);
    chk("R8", "slope frozen", int'(countPerStep), 361);
    chk("R9", "125 above 124", int'(alarmFlag), 1);

    // R10: alarm clears on the next in-range conversion
    convert("R10", 3, 1'b0, 1'b0, 0, 8'h7F, 8'h80);
    chk("R10", "alarm cleared", int'(alarmFlag), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule